// File: doc/BRIEF.md
# Reset configuration word loader

During hard reset, a bus master has to fetch its own configuration word and the words for up to seven configuration slaves from a byte-wide boot device. This block walks a fixed table of 32 single-byte entries. It reads each byte over a request/valid handshake, and it takes that byte from one fixed lane of the data bus, so the width of the boot device's port makes no difference.

Each group of four successive bytes is packed into one 32-bit word, with the earliest byte in the most significant position. Group 0 is the master's own word and groups 1 to 7 are the slave words. When the last byte arrives, all words are published together and a one-cycle done strobe is raised. The block also publishes the reset exception address. A core-prefix bit in the master word selects between a low base and a high base, and the address is that base plus 0x100. After this the block stays quiet until the next reset.

Top module: `cfgw_loader`

## Requirements
- R1: In the first cycle after reset is released, rd_req is 1, rd_addr is 0, done is 0, and master_word, slave_words, slave_valid and reset_vector are all zero.
- R2: The loader makes exactly 32 reads. The address of read n is 8*n (0, 8, ... 248), and it moves to the next address in the cycle after a cycle with rd_valid high.
- R3: While rd_req is high and rd_valid is low, rd_addr keeps its value.
- R4: Only bus bits [63:56] (byte lane 0) are captured on each read. All other bus bits have no effect on any output.
- R5: Reads 4g to 4g+3 form word g. Read 4g goes to bits [31:24] and read 4g+3 goes to bits [7:0].
- R6: Word 0 appears on master_word. Word k (k = 1..7) appears on slave_words[32k-1:32k-32].
- R7: In the cycle after the 32nd accepted read, done is 1 for exactly one cycle and slave_valid becomes 7'h7F. rd_req is 0 from then on.
- R8: Until done is asserted, master_word, slave_words and reset_vector read zero.
- R9: reset_vector is 32'h0000_0100 when master_word bit 20 is 0, and 32'hFFF0_0100 when it is 1.
- R10: After loading completes, rd_valid and rd_data have no effect. The outputs keep their values and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | output | 1 | Read request to the boot device |
| rd_addr | output | 32 | Byte address of the current read |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 64 | Read data bus; byte lane 0 is bits [63:56] |
| master_word | output | 32 | Configuration word for this master |
| slave_words | output | 224 | Words for slaves 1..7, slave 1 in the low 32 bits |
| slave_valid | output | 7 | Per-slave word valid flags |
| done | output | 1 | One-cycle strobe when all words are loaded |
| reset_vector | output | 32 | Reset exception address derived from the master word |

## Verification
The bench loads three tables: two random tables, one with the core-prefix bit forced clear and one with it forced set, and one table of all-ones bytes. The all-ones table carries all-zero filler on the other lanes, and the random tables carry random filler there. Comparing the random tables tells a wrong byte order or a wrong word slot apart from a correct one. The filler shows whether any bit outside lane 0 leaks into a word, and the two prefix settings tell the two reset vector bases apart. Response latency is random between 0 and 3 cycles per read in the random tables and zero in the all-ones table, which separates address holding from back-to-back advancing. After each load, extra valid pulses show that the finished block ignores the bus.

// File: rtl/cfgw_pkg.sv
// Shared types and constants for the reset configuration word loader.
package cfgw_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        SEQ_FETCH    = 1'b0,
        SEQ_FINISHED = 1'b1
    } seq_state_e;
endpackage

// File: rtl/cfgw_seq.sv
// Read sequencer: issues TOTAL reads at addresses 0, STRIDE, 2*STRIDE ...
// Assumes the device answers each request with one rd_valid cycle.
// After the last read it raises done for one cycle and parks.
module cfgw_seq
    import cfgw_pkg::*;
#(
    parameter int TOTAL  = 32,
    parameter int ADDR_W = 32,
    parameter int STRIDE = 8,
    localparam int IDX_W = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cap_en,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              cap_last,
    output logic              done
);
    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;

    // Combinational request, address and capture strobes
    always_comb begin
        rd_req   = (state_q == SEQ_FETCH);
        rd_addr  = ADDR_W'(idx_q) * ADDR_W'(STRIDE);
        cap_en   = rd_req && rd_valid;
        cap_idx  = idx_q;
        cap_last = (idx_q == IDX_W'(TOTAL - 1));
        done     = done_q;
    end

    // Advance the read index on each accepted byte; finish after the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_FETCH;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cap_en) begin
                if (cap_last) begin
                    state_q <= SEQ_FINISHED;
                    done_q  <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_addr == $past(rd_addr)));
    // R2
    addr_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !cap_last) |=> (rd_addr == $past(rd_addr) + ADDR_W'(STRIDE)));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rd_valid) && !rd_req));
    // R7
    req_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_req);
endmodule

// File: rtl/cfgw_assembler.sv
// Word assembler: places each captured lane-0 byte into its word slot,
// earliest byte of a group in the most significant position.
// Assumes capture indices arrive in order; words stay hidden (zero) until published.
module cfgw_assembler
    import cfgw_pkg::*;
#(
    parameter int NUM_WORDS      = 8,
    parameter int BYTES_PER_WORD = 4,
    parameter int BUS_W          = 64,
    localparam int WORD_W = BYTES_PER_WORD * BYTE_W,
    localparam int TOTAL  = NUM_WORDS * BYTES_PER_WORD,
    localparam int IDX_W  = $clog2(TOTAL),
    localparam int BSEL_W = $clog2(BYTES_PER_WORD)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_en,
    input  logic [IDX_W-1:0]            cap_idx,
    input  logic                        cap_last,
    input  logic [BUS_W-1:0]            bus_data,
    output logic [NUM_WORDS*WORD_W-1:0] words,
    output logic                        published
);
    logic [BYTE_W-1:0]             lane_byte;
    logic [BSEL_W-1:0]             byte_pos;
    logic [IDX_W-BSEL_W-1:0]       word_sel;
    logic [NUM_WORDS*WORD_W-1:0]   raw_q;
    logic                          pub_q;

    // Extract lane 0 and split the index into word and byte position
    always_comb begin
        lane_byte = bus_data[BUS_W-1 -: BYTE_W];
        byte_pos  = cap_idx[BSEL_W-1:0];
        word_sel  = cap_idx[IDX_W-1:BSEL_W];
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        // Store the captured byte in this word, MSB-first by byte position
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_q[w*WORD_W +: WORD_W] <= '0;
            end else if (cap_en && (word_sel == (IDX_W-BSEL_W)'(w))) begin
                raw_q[w*WORD_W + (BYTES_PER_WORD-1-int'(byte_pos))*BYTE_W +: BYTE_W] <= lane_byte;
            end
        end
    end

    // Publish all words together once the final byte is stored
    always_ff @(posedge clk) begin
        if (!rst_n)                 pub_q <= 1'b0;
        else if (cap_en && cap_last) pub_q <= 1'b1;
    end

    // Gate outputs until publication
    always_comb begin
        words     = pub_q ? raw_q : '0;
        published = pub_q;
    end

    // R10
    no_capture_after_pub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        published |-> !cap_en);
    // R10
    words_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (published && $past(published)) |-> $stable(words));
endmodule

// File: rtl/cfgw_vector.sv
// Reset vector select: chooses the low or high exception base from the
// core-prefix bit of the master word and adds the reset offset.
// Assumes master_word is already zero while not published.
module cfgw_vector #(
    parameter int          WORD_W     = 32,
    parameter int          PREFIX_BIT = 20,
    parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000,
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0100
) (
    input  logic [WORD_W-1:0] master_word,
    input  logic              published,
    output logic [31:0]       reset_vector
);
    // Select base and apply offset once the words are published
    always_comb begin
        if (!published)                   reset_vector = '0;
        else if (master_word[PREFIX_BIT]) reset_vector = HIGH_BASE + VEC_OFFSET;
        else                              reset_vector = VEC_OFFSET;
    end
endmodule

// File: rtl/cfgw_loader.sv
// Reset configuration word loader top: sequences 32 strided byte reads,
// assembles master and slave words and derives the reset vector.
// Assumes a boot device that answers each held request with one valid cycle.
module cfgw_loader
    import cfgw_pkg::*;
#(
    parameter int          NUM_WORDS      = 8,
    parameter int          BYTES_PER_WORD = 4,
    parameter int          ADDR_W         = 32,
    parameter int          ADDR_STRIDE    = 8,
    parameter int          BUS_W          = 64,
    parameter int          PREFIX_BIT     = 20,
    parameter logic [31:0] HIGH_BASE      = 32'hFFF0_0000,
    parameter logic [31:0] VEC_OFFSET     = 32'h0000_0100,
    localparam int WORD_W = BYTES_PER_WORD * BYTE_W,
    localparam int TOTAL  = NUM_WORDS * BYTES_PER_WORD,
    localparam int IDX_W  = $clog2(TOTAL)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic                            rd_req,
    output logic [ADDR_W-1:0]               rd_addr,
    input  logic                            rd_valid,
    input  logic [BUS_W-1:0]                rd_data,
    output logic [WORD_W-1:0]               master_word,
    output logic [(NUM_WORDS-1)*WORD_W-1:0] slave_words,
    output logic [NUM_WORDS-2:0]            slave_valid,
    output logic                            done,
    output logic [31:0]                     reset_vector
);
    logic                        cap_en;
    logic [IDX_W-1:0]            cap_idx;
    logic                        cap_last;
    logic [NUM_WORDS*WORD_W-1:0] words;
    logic                        published;

    cfgw_seq #(
        .TOTAL (TOTAL),
        .ADDR_W(ADDR_W),
        .STRIDE(ADDR_STRIDE)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_valid(rd_valid),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .cap_last(cap_last),
        .done    (done)
    );

    cfgw_assembler #(
        .NUM_WORDS     (NUM_WORDS),
        .BYTES_PER_WORD(BYTES_PER_WORD),
        .BUS_W         (BUS_W)
    ) asm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .cap_last (cap_last),
        .bus_data (rd_data),
        .words    (words),
        .published(published)
    );

    cfgw_vector #(
        .WORD_W    (WORD_W),
        .PREFIX_BIT(PREFIX_BIT),
        .HIGH_BASE (HIGH_BASE),
        .VEC_OFFSET(VEC_OFFSET)
    ) vec_i (
        .master_word (master_word),
        .published   (published),
        .reset_vector(reset_vector)
    );

    // Split the word array into master and slave outputs
    always_comb begin
        master_word = words[WORD_W-1:0];
        slave_words = words[NUM_WORDS*WORD_W-1:WORD_W];
        slave_valid = {(NUM_WORDS-1){published}};
    end

    // R8
    hidden_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (reset_vector == '0 && master_word == '0));
    // R7
    valid_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (slave_valid == '1));
endmodule

// File: tb/cfgw_loader_tb.sv
// Bench: random and directed tables served with random latency.
module cfgw_loader_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_req;
    logic [31:0]  rd_addr;
    logic         rd_valid = 1'b0;
    logic [63:0]  rd_data = '0;
    logic [31:0]  master_word;
    logic [223:0] slave_words;
    logic [6:0]   slave_valid;
    logic         done;
    logic [31:0]  reset_vector;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] tbl [32];

    always #4 clk = ~clk;  // 125 MHz

    cfgw_loader dut_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .master_word(master_word),
        .slave_words(slave_words), .slave_valid(slave_valid), .done(done),
        .reset_vector(reset_vector)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int g);
        return {tbl[4*g], tbl[4*g+1], tbl[4*g+2], tbl[4*g+3]};
    endfunction

    function automatic logic [31:0] exp_vec();
        return exp_word(0)[20] ? 32'hFFF0_0100 : 32'h0000_0100;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        rd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_req == 1'b1, "R1 rd_req", 32'(rd_req), 32'd1);
        chk(rd_addr == 32'd0, "R1 rd_addr", rd_addr, 32'd0);
        chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
        chk(master_word == 32'd0 && slave_words == '0 && slave_valid == '0,
            "R1 words", master_word, 32'd0);
        chk(reset_vector == 32'd0, "R1 vector", reset_vector, 32'd0);
    endtask

    // Serve the 32 reads; random_lat selects 0..3 wait cycles per read
    task automatic serve(input bit random_lat, input bit zero_fill);
        for (int i = 0; i < 32; i++) begin
            int lat;
            chk(rd_addr == 32'(i * 8), "R2 address", rd_addr, 32'(i * 8));
            lat = random_lat ? int'($urandom % 4) : 0;
            for (int k = 0; k < lat; k++) begin
                @(posedge clk);
                @(negedge clk);
                chk(rd_addr == 32'(i * 8), "R3 address hold", rd_addr, 32'(i * 8));
            end
            if (i == 20) begin
                chk(master_word == 32'd0 && reset_vector == 32'd0 && slave_words == '0,
                    "R8 hidden before done", master_word, 32'd0);
                chk(done == 1'b0, "R8 done low", 32'(done), 32'd0);
            end
            rd_valid = 1'b1;
            rd_data = {tbl[i], zero_fill ? 56'd0 : 56'({$urandom, $urandom})};
            @(posedge clk);
            @(negedge clk);
            rd_valid = 1'b0;
            rd_data = {$urandom, $urandom};
        end
    endtask

    task automatic check_result();
        chk(done == 1'b1, "R7 done pulse", 32'(done), 32'd1);
        chk(rd_req == 1'b0, "R7 req dropped", 32'(rd_req), 32'd0);
        chk(slave_valid == 7'h7F, "R7 slave_valid", 32'(slave_valid), 32'h7F);
        chk(master_word == exp_word(0), "R5 R6 master word", master_word, exp_word(0));
        for (int s = 1; s < 8; s++)
            chk(slave_words[32*s-1 -: 32] == exp_word(s), "R5 R6 slave word",
                slave_words[32*s-1 -: 32], exp_word(s));
        chk(reset_vector == exp_vec(), "R9 reset vector", reset_vector, exp_vec());
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", 32'(done), 32'd0);
        // R10: bus activity after completion is ignored
        for (int k = 0; k < 3; k++) begin
            rd_valid = 1'b1;
            rd_data = {$urandom, $urandom};
            @(posedge clk);
            @(negedge clk);
            chk(done == 1'b0 && rd_req == 1'b0, "R10 stays idle", 32'(done), 32'd0);
            chk(master_word == exp_word(0), "R10 master frozen", master_word, exp_word(0));
            chk(slave_words[223:192] == exp_word(7), "R10 slave frozen",
                slave_words[223:192], exp_word(7));
        end
        rd_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1357));
        // Run A: random table, prefix bit clear (R4 with random filler)
        for (int i = 0; i < 32; i++) tbl[i] = 8'($urandom);
        tbl[1][4] = 1'b0;
        do_reset();
        serve(1'b1, 1'b0);
        check_result();
        // Run B: random table, prefix bit set
        for (int i = 0; i < 32; i++) tbl[i] = 8'($urandom);
        tbl[1][4] = 1'b1;
        do_reset();
        serve(1'b1, 1'b0);
        check_result();
        // Run C: directed all-ones bytes, zero filler, back-to-back responses
        for (int i = 0; i < 32; i++) tbl[i] = 8'hFF;
        do_reset();
        serve(1'b0, 1'b1);
        check_result();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule